// File: doc/BRIEF.md
# Octal Converter Register Bank

This block sits behind a serial receiver. It takes each committed 16-bit word and turns it into the register state of an eight-channel, 8-bit converter. The upper four bits of a word select a target and the lower twelve carry its data. The bank holds eight channel input codes, a global control register, a per-pair control register and a shared preset value. One group of four addresses writes a code to the even channel of a pair and the bitwise inverse of that code to the odd channel. A mode bit lets the host send signed codes, which are converted to offset binary before they are stored.

Each channel's code reaches its output through a level-sensitive load gate. While load is low the stored codes show through at once. While load is high the outputs hold the value they had when load was last low. An active-low preset input overrides every channel asynchronously with the stored preset value. The bank also drives the power, speed, reference and daisy-chain enable settings to the analogue and serial parts of the chip.

Top module: `octdac_regbank`

## Requirements
- R1: After reset all eight channel outputs read 0 and every control output (chipPowerDown, chainOutEn, refSelect, pairPowerDown, pairFast, twos mode) is 0.
- R2: A word with address 0..7 stores data bits 11:4 as the code of channel 0..7 (channel 0 on dacCode[7:0], channel k on dacCode[8k+7:8k]), and data bits 3:0 are ignored; with loadN low the new code shows on the clock after the write.
- R3: A word with address 12..15 (pair p = address bits 1:0) stores the code in channel 2p and its bitwise inverse in channel 2p+1, so writing 255 to address 12 gives channel 0 = 255 and channel 1 = 0.
- R4: When the input-mode bit is 1, bit 7 of every received code (channel, pair and preset writes) is inverted before storage, so 0x80 is stored as 0 and 0x7F as 255; for pair writes the inversion is applied before the complement.
- R5: While loadN is low the outputs follow the stored codes; while loadN is high the outputs stay frozen, and codes written during that time appear once loadN goes low again.
- R6: While presetN is low every channel output shows the preset value (address 10, bits 11:4) without waiting for a clock; the preset value is 0 after reset.
- R7: Address 8 sets chipPowerDown from bit 4, chainOutEn from bit 3, refSelect from bits 2:1 (00 external, 01 internal low, 10 internal high, 11 external) and the input-mode bit from bit 0.
- R8: Address 9 sets pairPowerDown from bits 7:4 and pairFast from bits 3:0 (1 = fast), where index 0 is pair 0/1 and index 3 is pair 6/7.
- R9: Address 11, bits 11:5 of address 8 and bits 11:8 of address 9 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | Commit strobe for wordIn |
| wordIn | input | 16 | Address in bits 15:12, data in bits 11:0 |
| loadN | input | 1 | Level-sensitive load gate, low = transparent |
| presetN | input | 1 | Asynchronous active-low preset override |
| dacCode | output | 64 | Eight 8-bit channel codes, channel k at bits 8k+7:8k |
| pairPowerDown | output | 4 | Power-down per channel pair |
| pairFast | output | 4 | Speed per channel pair, 1 = fast |
| chipPowerDown | output | 1 | Whole-converter power-down |
| chainOutEn | output | 1 | Daisy-chain output enable |
| refSelect | output | 2 | Reference source code |
| twosMode | output | 1 | Input format, 1 = signed codes |

## Verification
A register write can land in the same cycle as a preset override or a load freeze, and the output must then show the override or the frozen value. The new code must appear only after the override or the freeze is released. The bench writes codes and pairs while presetN or loadN is held, checks the outputs against a model of the stored and held values, and releases each input in turn. Random traffic changes the gates at random points between writes, so those cases also occur with signed mode on and off.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int CHANNELS = 8;
  localparam int CODE_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 12;
  localparam int WORD_W   = ADDR_W + DATA_W;
  localparam int PAIRS    = CHANNELS / 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL_GLOBAL = 4'd8,
    ADR_CTRL_PAIR   = 4'd9,
    ADR_PRESET      = 4'd10,
    ADR_RESERVED    = 4'd11
  } addr_e;

  typedef struct packed {
    logic [CHANNELS-1:0] codeWe;
    logic                pairWrite;
    logic                presetWe;
    logic [CODE_W-1:0]   primary;
  } strobe_t;
endpackage

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wordValid,
  input  logic [WORD_W-1:0]     wordIn,
  output strobe_t               strobes,
  output logic [PAIRS-1:0]      pairPowerDown,
  output logic [PAIRS-1:0]      pairFast,
  output logic                  chipPowerDown,
  output logic                  chainOutEn,
  output logic [1:0]            refSelect,
  output logic                  twosMode
);
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [CODE_W-1:0] rawCode;

  assign addr    = wordIn[WORD_W-1:DATA_W];
  assign data    = wordIn[DATA_W-1:0];
  assign rawCode = data[DATA_W-1:DATA_W-CODE_W];

  always_comb begin
    strobes           = '0;
    strobes.primary   = rawCode ^ {twosMode, {(CODE_W-1){1'b0}}};
    if (wordValid) begin
      if (addr < ADDR_W'(CHANNELS)) begin
        strobes.codeWe[addr[2:0]] = 1'b1;
      end else if (addr[ADDR_W-1:ADDR_W-2] == 2'b11) begin
        strobes.pairWrite = 1'b1;
        strobes.codeWe[{addr[1:0], 1'b0}] = 1'b1;
        strobes.codeWe[{addr[1:0], 1'b1}] = 1'b1;
      end else if (addr == ADR_PRESET) begin
        strobes.presetWe = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipPowerDown <= 1'b0;
      chainOutEn    <= 1'b0;
      refSelect     <= 2'b00;
      twosMode      <= 1'b0;
      pairPowerDown <= '0;
      pairFast      <= '0;
    end else if (wordValid) begin
      if (addr == ADR_CTRL_GLOBAL) begin
        chipPowerDown <= data[4];
        chainOutEn    <= data[3];
        refSelect     <= data[2:1];
        twosMode      <= data[0];
      end else if (addr == ADR_CTRL_PAIR) begin
        pairPowerDown <= data[2*PAIRS-1:PAIRS];
        pairFast      <= data[PAIRS-1:0];
      end
    end
  end
endmodule

// File: rtl/octdac_datapath.sv
module octdac_datapath
  import octdac_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobes,
  input  logic                       loadN,
  input  logic                       presetN,
  output logic [CHANNELS*CODE_W-1:0] dacCode
);
  logic [CODE_W-1:0] presetReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 presetReg <= '0;
    else if (strobes.presetWe) presetReg <= strobes.primary;
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [CODE_W-1:0] codeReg;
    logic [CODE_W-1:0] heldReg;
    logic [CODE_W-1:0] codeNext;
    logic [CODE_W-1:0] writeVal;

    if (ch % 2 == 1) begin : g_odd
      assign writeVal = strobes.pairWrite ? ~strobes.primary : strobes.primary;
    end else begin : g_even
      assign writeVal = strobes.primary;
    end

    assign codeNext = strobes.codeWe[ch] ? writeVal : codeReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeReg <= '0;
        heldReg <= '0;
      end else begin
        codeReg <= codeNext;
        if (!loadN) heldReg <= codeNext;
      end
    end

    assign dacCode[ch*CODE_W +: CODE_W] = !presetN ? presetReg
                                        : (loadN ? heldReg : codeReg);
  end
endmodule

// File: rtl/octdac_regbank.sv
module octdac_regbank (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic [15:0] wordIn,
  input  logic        loadN,
  input  logic        presetN,
  output logic [63:0] dacCode,
  output logic [3:0]  pairPowerDown,
  output logic [3:0]  pairFast,
  output logic        chipPowerDown,
  output logic        chainOutEn,
  output logic [1:0]  refSelect,
  output logic        twosMode
);
  import octdac_pkg::*;

  strobe_t strobes;

  octdac_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .strobes(strobes), .pairPowerDown(pairPowerDown), .pairFast(pairFast),
    .chipPowerDown(chipPowerDown), .chainOutEn(chainOutEn),
    .refSelect(refSelect), .twosMode(twosMode)
  );

  octdac_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadN(loadN),
    .presetN(presetN), .dacCode(dacCode)
  );
endmodule

// File: rtl/octdac_regbank_chk.sv
module octdac_regbank_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic [15:0] wordIn,
  input logic        loadN,
  input logic        presetN,
  input logic [63:0] dacCode,
  input logic [3:0]  pairPowerDown,
  input logic [3:0]  pairFast,
  input logic        chipPowerDown,
  input logic        chainOutEn,
  input logic [1:0]  refSelect,
  input logic        twosMode
);
  logic [3:0] pairInverse;
  logic       allEqual;

  always_comb begin
    allEqual = 1'b1;
    for (int k = 1; k < 8; k++)
      if (dacCode[k*8 +: 8] != dacCode[7:0]) allEqual = 1'b0;
    for (int p = 0; p < 4; p++)
      pairInverse[p] = (dacCode[16*p +: 8] == ~dacCode[16*p+8 +: 8]);
  end

  // R6: preset drives one common value onto every channel
  p_preset_common_r6: assert property (@(posedge clk) disable iff (!rstN)
    !presetN |-> allEqual);

  // R5: outputs hold while load stays high
  p_load_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && $past(loadN) && presetN && $past(presetN)) |-> $stable(dacCode));

  // R3: pair write leaves the two channels complementary
  p_pair_inverse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIn[15:14] == 2'b11) ##1 (!loadN && presetN)
      |-> pairInverse[$past(wordIn[13:12])]);

  // R9: reserved address changes no control output
  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIn[15:12] == 4'd11)
      |=> $stable({pairPowerDown, pairFast, chipPowerDown, chainOutEn, refSelect, twosMode}));

  // R7: global control fields follow the write
  p_global_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIn[15:12] == 4'd8)
      |=> ({chipPowerDown, chainOutEn, refSelect, twosMode} == $past(wordIn[4:0])));

  // R8: pair control fields follow the write
  p_pair_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordIn[15:12] == 4'd9)
      |=> ({pairPowerDown, pairFast} == $past(wordIn[7:0])));
endmodule

bind octdac_regbank octdac_regbank_chk i_chk (.*);

// File: tb/test_octdac_regbank.sv
module test_octdac_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordIn = '0;
  logic        loadN = 1'b0;
  logic        presetN = 1'b1;
  logic [63:0] dacCode;
  logic [3:0]  pairPowerDown, pairFast;
  logic        chipPowerDown, chainOutEn, twosMode;
  logic [1:0]  refSelect;

  octdac_regbank i_octdac_regbank (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] codeM [8];
  logic [7:0] heldM [8];
  logic [7:0] presetM;
  logic       pdM, chainM, modeM;
  logic [1:0] refM;
  logic [3:0] pairPdM, pairFastM;

  function automatic logic [7:0] expChan(int k);
    if (!presetN) return presetM;
    return loadN ? heldM[k] : codeM[k];
  endfunction

  task automatic modelWrite(logic [3:0] a, logic [11:0] d);
    logic [7:0] conv;
    conv = d[11:4] ^ {modeM, 7'b0};
    if (a < 8) codeM[a] = conv;
    else if (a == 8) begin
      pdM = d[4]; chainM = d[3]; refM = d[2:1]; modeM = d[0];
    end else if (a == 9) begin
      pairPdM = d[7:4]; pairFastM = d[3:0];
    end else if (a == 10) presetM = conv;
    else if (a >= 12) begin
      codeM[2*(a-12)]   = conv;
      codeM[2*(a-12)+1] = ~conv;
    end
    if (!loadN) for (int k = 0; k < 8; k++) heldM[k] = codeM[k];
  endtask

  task automatic writeWord(logic [3:0] a, logic [11:0] d);
    @(negedge clk);
    wordValid = 1'b1;
    wordIn = {a, d};
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic setLoad(logic v);
    @(negedge clk);
    loadN = v;
    @(negedge clk);
    if (!v) for (int k = 0; k < 8; k++) heldM[k] = codeM[k];
  endtask

  task automatic setPreset(logic v);
    @(negedge clk);
    presetN = v;
    #1;
  endtask

  task automatic checkAll(string req);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < 8; k++)
      if (dacCode[k*8 +: 8] !== expChan(k)) begin
        ok = 1'b0;
        $display("FAIL %s channel %0d actual %0d expected %0d", req, k,
                 dacCode[k*8 +: 8], expChan(k));
      end
    if ({pairPowerDown, pairFast, chipPowerDown, chainOutEn, refSelect, twosMode} !==
        {pairPdM, pairFastM, pdM, chainM, refM, modeM}) begin
      ok = 1'b0;
      $display("FAIL %s control actual %h expected %h", req,
               {pairPowerDown, pairFast, chipPowerDown, chainOutEn, refSelect, twosMode},
               {pairPdM, pairFastM, pdM, chainM, refM, modeM});
    end
    checks++;
    if (!ok) fails++;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] a;
    logic [11:0] d;
    void'($urandom(32'd2024));
    for (int k = 0; k < 8; k++) begin codeM[k] = 0; heldM[k] = 0; end
    presetM = 0; pdM = 0; chainM = 0; modeM = 0; refM = 0; pairPdM = 0; pairFastM = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    setPreset(1'b0);
    checkAll("R6 preset before any preset write");
    setPreset(1'b1);

    writeWord(4'd3, 12'hA5F);
    checkAll("R2 channel write, low bits ignored");
    writeWord(4'd12, 12'hFF0);
    checkAll("R3 pair write 255");
    writeWord(4'd15, 12'h3C0);
    checkAll("R3 pair write last pair");

    writeWord(4'd8, 12'hFE0);
    checkAll("R9 unused global bits");
    writeWord(4'd9, 12'hF00);
    checkAll("R9 unused pair bits");
    writeWord(4'd8, 12'h01F);
    checkAll("R7 global fields");
    writeWord(4'd9, 12'h0A5);
    checkAll("R8 pair fields");
    writeWord(4'd11, 12'hFFF);
    checkAll("R9 reserved address");

    writeWord(4'd0, 12'h800);
    checkAll("R4 signed min");
    writeWord(4'd1, 12'h7F0);
    checkAll("R4 signed max");
    writeWord(4'd13, 12'h000);
    checkAll("R4 signed before complement");
    writeWord(4'd10, 12'h050);
    setPreset(1'b0);
    checkAll("R4 R6 signed preset");
    writeWord(4'd5, 12'h120);
    checkAll("R6 write under preset");
    setPreset(1'b1);
    checkAll("R6 release shows write");

    writeWord(4'd8, 12'h000);
    setLoad(1'b1);
    writeWord(4'd6, 12'hEE0);
    checkAll("R5 frozen during write");
    writeWord(4'd14, 12'h110);
    checkAll("R5 frozen pair write");
    setLoad(1'b0);
    checkAll("R5 load releases codes");

    for (int it = 0; it < 400; it++) begin
      a = 4'($urandom_range(0, 15));
      d = 12'($urandom_range(0, 4095));
      if ($urandom_range(0, 7) == 0) setLoad(~loadN);
      if ($urandom_range(0, 9) == 0) setPreset(~presetN);
      writeWord(a, d);
      checkAll("R2 R3 R4 R5 R6 R7 R8 random");
    end
    setPreset(1'b1);
    setLoad(1'b0);
    checkAll("R5 final release");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule